// File: doc/BRIEF.md
# Exact LRU Recency Tracker (Bit-Matrix Form)

This block keeps the exact least-recently-used order of the ways in one cache set. It holds a square bit matrix with one row and one column per way. A touch strobe, together with the number of the way that was referenced, updates the matrix in a single clock cycle. The block always presents the way that should be evicted next, and it also presents a recency rank for every way.

A cache instantiates the tracker once per set, or stores the matrix per set and indexes it. The tracker does not pick invalid ways before valid ones, and it does not compare tags. The surrounding cache logic does both. It raises `touch` on every hit, and on every fill it raises `touch` with the way that was filled.

Row `i` of the matrix has bit `j` set when way `i` was referenced more recently than way `j`. The row with the smallest binary value therefore belongs to the least recent way. The number of ones in a row is the number of ways that are older than that way.

Top module: `lru_matrix`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `victim` is 0 and every rank field is 0.
- R2: When `touch` is high at a rising edge, the new state is visible after that edge. With more than one way, `victim` then differs from the way just touched.
- R3: After a touch, the rank of the touched way is WAYS-1 (most recent). No two ways ever hold rank WAYS-1 at the same time.
- R4: `victim` is the way that has gone longest without a touch. Ways never touched since reset count as older than any touched way. Ties between them go to the lowest-numbered way. The rank of the way named by `victim` is always 0.
- R5: While `touch` is low, the `victim` output and all ranks keep their values.
- R6: After the sequence 0,1,2,3,2,1,0,3,2,3 on 4 ways, `victim` is 1. The ranks of ways 0 to 3 are 1, 0, 2 and 3, which gives the order 3,2,0,1 from most to least recent.
- R7: The rank of way i sits in bits [i*WW +: WW] of `rank_flat`, where WW is max(1, log2 WAYS). Its value is the number of ways that were last touched before way i, with never-touched ways counted as before any touch. Its value is 0 if way i has not been touched since reset.
- R8: Touching the same way again leaves `victim` and every rank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the matrix |
| touch | input | 1 | Reference strobe for one cycle |
| touch_way | input | WW | Way referenced when `touch` is high |
| victim | output | WW | Least recently used way |
| rank_flat | output | WAYS*WW | Per-way recency rank, 0 = oldest |

## Verification
A wrong bit in the matrix shows up at the ports no later than the cycle after the touch that left it wrong. The rank of at least one way moves off the value predicted from the touch history. Depending on the bit, the victim may also move to a different way or keep a rank other than 0. The bench keeps its own ordered recency list and last-touch timestamps, and after every touch it compares both the victim and all ranks against them. A corrupted entry is therefore reported on the very next sample, not only when it happens to change the eviction choice.

// File: rtl/lru_matrix.sv
module lru_matrix #(
  parameter int WAYS = 4,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic [WW-1:0]      touch_way,
  output logic [WW-1:0]      victim,
  output logic [WAYS*WW-1:0] rank_flat
);

  logic [WAYS-1:0] mtx [WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) mtx[i] <= '0;
    end else if (touch) begin
      for (int i = 0; i < WAYS; i++)
        for (int j = 0; j < WAYS; j++)
          if (j == int'(touch_way)) mtx[i][j] <= 1'b0;
          else if (i == int'(touch_way)) mtx[i][j] <= 1'b1;
    end
  end

  generate
    if (WAYS == 1) begin : g_single
      assign victim = '0;
    end else begin : g_multi
      always_comb begin
        victim = '0;
        for (int i = 1; i < WAYS; i++)
          if (mtx[i] < mtx[victim]) victim = WW'(i);
      end
    end
  endgenerate

  for (genvar g = 0; g < WAYS; g++) begin : g_rank
    assign rank_flat[g*WW +: WW] = WW'($countones(mtx[g]));
  end

endmodule

module lru_matrix_check #(
  parameter int WAYS = 4,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               touch,
  input logic [WW-1:0]      touch_way,
  input logic [WW-1:0]      victim,
  input logic [WAYS*WW-1:0] rank_flat
);

  function automatic int rank_of(input logic [WAYS*WW-1:0] f, input logic [WW-1:0] w);
    return int'(f[w*WW +: WW]);
  endfunction

  logic [WAYS-1:0] top_flags;
  always_comb
    for (int i = 0; i < WAYS; i++)
      top_flags[i] = (int'(rank_flat[i*WW +: WW]) == WAYS - 1);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (victim == '0 && rank_flat == '0));

  p_not_victim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && WAYS > 1) |=> victim != $past(touch_way));

  p_touch_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> rank_of(rank_flat, $past(touch_way)) == WAYS - 1);

  p_single_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (WAYS == 1) || $onehot0(top_flags));

  p_victim_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rank_of(rank_flat, victim) == 0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !touch |=> ($stable(victim) && $stable(rank_flat)));

endmodule

bind lru_matrix lru_matrix_check #(.WAYS(WAYS)) u_check (
  .clk(clk), .rst_n(rst_n), .touch(touch), .touch_way(touch_way),
  .victim(victim), .rank_flat(rank_flat)
);

// File: tb/lru_matrix_test.sv
`timescale 1ns/1ps
module lru_matrix_test;
  localparam int WAYS = 4;
  localparam int WW = 2;

  logic clk = 0, rst_n = 0, touch = 0;
  logic [WW-1:0] touch_way = '0;
  logic [WW-1:0] victim;
  logic [WAYS*WW-1:0] rank_flat;

  int errors = 0, checks = 0, tstamp = 0;
  bit done = 0;
  int order [WAYS];
  int last [WAYS];

  always #4 clk = ~clk;

  lru_matrix #(.WAYS(WAYS)) uut (.clk(clk), .rst_n(rst_n), .touch(touch),
    .touch_way(touch_way), .victim(victim), .rank_flat(rank_flat));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < WAYS; i++) begin order[i] = i; last[i] = 0; end
    tstamp = 0;
  endtask

  function automatic int model_rank(int w);
    int n = 0;
    if (last[w] == 0) return 0;
    for (int j = 0; j < WAYS; j++) if (j != w && last[j] < last[w]) n++;
    return n;
  endfunction

  task automatic check_all(string req);
    chk(req, "victim", int'(victim), order[0]);
    for (int i = 0; i < WAYS; i++)
      chk(req, $sformatf("rank[%0d]", i), int'(rank_flat[i*WW +: WW]), model_rank(i));
  endtask

  task automatic do_touch(int w, string req);
    int pos = 0;
    @(negedge clk);
    touch = 1; touch_way = WW'(w);
    @(negedge clk);
    touch = 0;
    for (int i = 0; i < WAYS; i++) if (order[i] == w) pos = i;
    for (int i = pos; i < WAYS - 1; i++) order[i] = order[i+1];
    order[WAYS-1] = w;
    tstamp++; last[w] = tstamp;
    check_all(req);
    chk(req, "touched way not victim (R2)", int'(victim != WW'(w)), 1);
    chk(req, "touched way rank top (R3)", int'(rank_flat[w*WW +: WW]), WAYS - 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; touch = 0;
    model_reset();
    #1 check_all("R1");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic test_sequence();
    int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
    do_reset();
    foreach (seq[i]) do_touch(seq[i], "R4");
    chk("R6", "victim", int'(victim), 1);
    chk("R6", "rank way0", int'(rank_flat[0 +: WW]), 1);
    chk("R6", "rank way1", int'(rank_flat[WW +: WW]), 0);
    chk("R6", "rank way2", int'(rank_flat[2*WW +: WW]), 2);
    chk("R6", "rank way3", int'(rank_flat[3*WW +: WW]), 3);
  endtask

  task automatic test_tie();
    do_reset();
    do_touch(2, "R4");
    chk("R4", "tie lowest untouched", int'(victim), 0);
    do_touch(0, "R7");
    chk("R4", "tie next untouched", int'(victim), 1);
  endtask

  task automatic test_repeat();
    logic [WW-1:0] v0;
    logic [WAYS*WW-1:0] r0;
    do_reset();
    do_touch(1, "R8"); do_touch(3, "R8");
    v0 = victim; r0 = rank_flat;
    do_touch(3, "R8");
    chk("R8", "victim unchanged", int'(victim), int'(v0));
    chk("R8", "ranks unchanged", int'(rank_flat == r0), 1);
  endtask

  task automatic test_idle();
    logic [WW-1:0] v0;
    logic [WAYS*WW-1:0] r0;
    do_touch(2, "R7"); do_touch(0, "R7");
    v0 = victim; r0 = rank_flat;
    touch_way = WW'(1);
    repeat (5) @(negedge clk);
    chk("R5", "victim held", int'(victim), int'(v0));
    chk("R5", "ranks held", int'(rank_flat == r0), 1);
  endtask

  task automatic test_pseudo_random();
    logic [7:0] lfsr = 8'hA5;
    do_reset();
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_touch(int'(lfsr[1:0]), "R7");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    #1 check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    test_sequence();
    test_tie();
    test_repeat();
    test_idle();
    test_pseudo_random();
    do_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule